// File: doc/BRIEF.md
# Receive Descriptor Write-Back Coalescer

This block collects receive descriptors that have finished processing and are held on chip. It decides when to ask the memory write engine to copy them back to host memory as a single burst. Each completed descriptor arrives as a one-cycle pulse and adds one to a pending count. The block compares that count with a 6-bit threshold, and a granularity select sets the unit of the threshold: single descriptors or 64-byte cache lines. A descriptor is 16 bytes, so one cache line holds four descriptors. An explicit flush pulse empties everything pending. A threshold of zero turns coalescing off, and each descriptor then goes out in its own write-back.

The controller is a two-state machine. In `WB_IDLE` no request is pending. In `WB_ISSUE` the write-back request is driven with a fixed burst size. There are three transitions:
- *launch*: from `WB_IDLE` to `WB_ISSUE`, taken when the trigger condition holds on the registered count.
- *hold*: stay in `WB_ISSUE` while the acknowledge is low.
- *retire*: from `WB_ISSUE` back to `WB_IDLE` on acknowledge. At that edge the burst size is subtracted from the pending count.

The pending count saturates at 63. At that value the completion input is back-pressured and a write-back is forced.

Top module: `wb_coalesce_ctrl`

## Requirements
- R1: After reset no request is driven, the pending count is 0 and the block is ready to take completions.
- R2: With `gran_desc_i`=1 and a non-zero threshold, a request is raised only when the pending count is strictly greater than the threshold. It rises one cycle after the count first meets that condition, and `wb_cnt_o` equals the whole pending count at launch.
- R3: With `gran_desc_i`=0 and a non-zero threshold, one unit is a cache line of 4 descriptors. A request is raised once the pending count reaches at least 4 times the threshold, and it carries all pending descriptors.
- R4: With a threshold of 0, any pending descriptor launches a request with `wb_cnt_o` = 1.
- R5: A one-cycle `flush_i` pulse forces a request for all pending descriptors, whatever the threshold. A flush seen while no descriptor is pending is dropped. A flush that arrives while a request is active is kept and served after that request retires.
- R6: Only one request is outstanding at a time. `wb_req_o` stays high with `wb_cnt_o` unchanged until `wb_ack_i` is sampled high, and it is low in the cycle after the acknowledge.
- R7: At the acknowledge edge the pending count drops by `wb_cnt_o`. A completion accepted in that same cycle is still added.
- R8: At a pending count of 63, `desc_ready_o` is low and completions are dropped. A write-back of all 63 descriptors is forced even when the threshold cannot be exceeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_done_i | input | 1 | One-cycle pulse per completed descriptor |
| desc_ready_o | output | 1 | High when a completion can be taken |
| thresh_i | input | 6 | Coalescing threshold (0 disables coalescing) |
| gran_desc_i | input | 1 | 1: threshold in descriptors, 0: in 64-byte cache lines |
| flush_i | input | 1 | Explicit flush request pulse |
| wb_req_o | output | 1 | Write-back request to the memory write engine |
| wb_cnt_o | output | 6 | Descriptors in the requested burst |
| wb_ack_i | input | 1 | Write engine accepts the current request |
| pend_cnt_o | output | 6 | Descriptors currently pending |

## Verification
Several properties are checked on every cycle:
- A request holds steady until it is acknowledged.
- An acknowledge drains exactly the burst size while still counting a completion that lands in the same cycle.
- No burst is ever empty or larger than the pending count.
- In descriptor mode no launch happens without a strict threshold excess, a flush or a full count.
- Threshold zero always launches single-descriptor bursts.

Only the bench scenarios can show the rest:
- the exact burst sizes chosen at each threshold and granularity;
- that nothing launches below the threshold;
- that a flush on an empty queue is dropped while a flush during an active request is kept;
- that a completion is dropped at saturation.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    // Write-back controller states
    typedef enum logic [0:0] {
        WB_IDLE  = 1'b0,
        WB_ISSUE = 1'b1
    } wb_state_e;

    localparam int unsigned WBC_DESC_BYTES = 16;
    localparam int unsigned WBC_LINE_BYTES = 64;

endpackage

// File: rtl/wbc_pend_ctr.sv
module wbc_pend_ctr #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_i,
    input  logic             sub_en_i,
    input  logic [CNT_W-1:0] sub_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Burst size never exceeds the count it was taken from, and the add is
    // gated at the top when full, so modular arithmetic stays in range.
    always_comb begin
        cnt_d = cnt_q + CNT_W'(add_i) - (sub_en_i ? sub_val_i : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign full_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/wbc_trigger.sv
module wbc_trigger #(
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned TH_W       = 6,
    parameter int unsigned LINE_SHIFT = 2
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [TH_W-1:0]  thresh_i,
    input  logic             gran_desc_i,
    input  logic             flush_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] burst_o
);

    localparam int unsigned LINE_W = TH_W + LINE_SHIFT;
    localparam int unsigned CMP_W  = ((LINE_W > CNT_W) ? LINE_W : CNT_W) + 1;

    logic [CMP_W-1:0] cnt_x;
    logic [CMP_W-1:0] th_x;
    logic [CMP_W-1:0] line_lim;
    logic             has_pend;
    logic             is_full;
    logic             thr_zero;
    logic             desc_hit;
    logic             line_hit;

    always_comb begin
        cnt_x    = CMP_W'(cnt_i);
        th_x     = CMP_W'(thresh_i);
        line_lim = th_x << LINE_SHIFT;
        has_pend = (cnt_i != '0);
        is_full  = (cnt_i == {CNT_W{1'b1}});
        thr_zero = (thresh_i == '0);
        desc_hit = (cnt_x > th_x);
        line_hit = (cnt_x >= line_lim);

        fire_o = has_pend &&
                 (flush_i || is_full || thr_zero ||
                  (gran_desc_i ? desc_hit : line_hit));

        if (thr_zero && !flush_i && !is_full) burst_o = CNT_W'(1);
        else                                  burst_o = cnt_i;
    end

endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
    import wbc_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [CNT_W-1:0] burst_i,
    input  logic             ack_i,
    input  logic             flush_i,
    output logic             req_o,
    output logic [CNT_W-1:0] burst_o,
    output logic             flush_any_o
);

    wb_state_e        state_q;
    wb_state_e        state_d;
    logic [CNT_W-1:0] burst_q;
    logic             flush_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WB_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: launch, hold, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_IDLE:  if (fire_i) state_d = WB_ISSUE;
            WB_ISSUE: if (ack_i)  state_d = WB_IDLE;
            default:              state_d = WB_IDLE;
        endcase
    end

    // Burst size captured at launch; flush remembered across an active request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= '0;
            flush_q <= 1'b0;
        end else begin
            if (state_q == WB_IDLE && fire_i) burst_q <= burst_i;
            flush_q <= (state_q == WB_ISSUE) ? (flush_q | flush_i) : 1'b0;
        end
    end

    // Outputs
    always_comb begin
        req_o       = (state_q == WB_ISSUE);
        burst_o     = burst_q;
        flush_any_o = flush_i | flush_q;
    end

    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(burst_o)));

    assert_single_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

endmodule

// File: rtl/wb_coalesce_ctrl.sv
module wb_coalesce_ctrl #(
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned TH_W       = 6,
    parameter int unsigned DESC_BYTES = wbc_pkg::WBC_DESC_BYTES,
    parameter int unsigned LINE_BYTES = wbc_pkg::WBC_LINE_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_done_i,
    output logic             desc_ready_o,
    input  logic [TH_W-1:0]  thresh_i,
    input  logic             gran_desc_i,
    input  logic             flush_i,
    output logic             wb_req_o,
    output logic [CNT_W-1:0] wb_cnt_o,
    input  logic             wb_ack_i,
    output logic [CNT_W-1:0] pend_cnt_o
);

    localparam int unsigned DESC_PER_LINE = LINE_BYTES / DESC_BYTES;
    localparam int unsigned LINE_SHIFT    = $clog2(DESC_PER_LINE);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    logic             full;
    logic             accept;
    logic             retire;
    logic             fire;
    logic             flush_any;
    logic [CNT_W-1:0] pend;
    logic [CNT_W-1:0] burst_sel;

    assign desc_ready_o = !full;
    assign accept       = desc_done_i && !full;
    assign retire       = wb_req_o && wb_ack_i;
    assign pend_cnt_o   = pend;

    wbc_pend_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_i     (accept),
        .sub_en_i  (retire),
        .sub_val_i (wb_cnt_o),
        .cnt_o     (pend),
        .full_o    (full)
    );

    wbc_trigger #(
        .CNT_W      (CNT_W),
        .TH_W       (TH_W),
        .LINE_SHIFT (LINE_SHIFT)
    ) u_trig (
        .cnt_i       (pend),
        .thresh_i    (thresh_i),
        .gran_desc_i (gran_desc_i),
        .flush_i     (flush_any),
        .fire_o      (fire),
        .burst_o     (burst_sel)
    );

    wbc_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .burst_i     (burst_sel),
        .ack_i       (wb_ack_i),
        .flush_i     (flush_i),
        .req_o       (wb_req_o),
        .burst_o     (wb_cnt_o),
        .flush_any_o (flush_any)
    );

    assert_ack_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (pend == $past(pend) - $past(wb_cnt_o) + CNT_W'($past(accept))));

    assert_burst_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> (wb_cnt_o != '0 && wb_cnt_o <= pend));

    assert_desc_strict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wb_req_o) && $past(gran_desc_i) && $past(thresh_i) != '0) |->
        (CNT_W'($past(pend)) > CNT_W'($past(thresh_i)) || $past(flush_any) ||
         $past(pend) == CNT_MAX));

    assert_zero_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wb_req_o) && $past(thresh_i) == '0 && !$past(flush_any)) |->
        (wb_cnt_o == CNT_W'(1)));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !retire) |=> (pend == CNT_MAX));

endmodule

// File: tb/tb_wb_coalesce_ctrl.sv
module tb_wb_coalesce_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       desc_done = 1'b0;
    logic       desc_ready;
    logic [5:0] thresh = 6'd1;
    logic       gran = 1'b1;
    logic       flush = 1'b0;
    logic       wb_req;
    logic [5:0] wb_cnt;
    logic       wb_ack = 1'b0;
    logic [5:0] pend;

    int checks = 0;
    int errors = 0;
    int ack_delay = 0;
    int delay_cnt = 0;
    int exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    wb_coalesce_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_done_i  (desc_done),
        .desc_ready_o (desc_ready),
        .thresh_i     (thresh),
        .gran_desc_i  (gran),
        .flush_i      (flush),
        .wb_req_o     (wb_req),
        .wb_cnt_o     (wb_cnt),
        .wb_ack_i     (wb_ack),
        .pend_cnt_o   (pend)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_desc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) desc_done = 1'b1;
        end
        @(negedge clk) desc_done = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_burst(input int n);
        exp_q.push_back(n);
    endtask

    // Monitor: pops expected bursts and acknowledges after ack_delay cycles
    initial begin
        forever begin
            @(negedge clk);
            wb_ack = 1'b0;
            if (rst_n && wb_req) begin
                if (delay_cnt < ack_delay) begin
                    delay_cnt++;
                end else begin
                    delay_cnt = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected request", int'(wb_cnt), 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(int'(wb_cnt) == e, "R2 burst size", int'(wb_cnt), e);
                    end
                    wb_ack = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(wb_req == 1'b0, "R1 req", int'(wb_req), 0);
        check(pend == 6'd0, "R1 pend", int'(pend), 0);
        check(desc_ready == 1'b1, "R1 ready", int'(desc_ready), 1);
        rst_n = 1'b1;
        idle(2);

        // R2: descriptor units, strict greater-than
        thresh = 6'd3; gran = 1'b1;
        send_desc(3);
        idle(5);
        check(pend == 6'd3, "R2 below threshold pend", int'(pend), 3);
        check(wb_req == 1'b0, "R2 no request at threshold", int'(wb_req), 0);
        expect_burst(4);
        send_desc(1);
        idle(6);
        check(pend == 6'd0, "R2 drained", int'(pend), 0);

        // R3: cache-line units
        thresh = 6'd1; gran = 1'b0;
        send_desc(3);
        idle(5);
        check(pend == 6'd3, "R3 partial line", int'(pend), 3);
        expect_burst(4);
        send_desc(1);
        idle(6);
        check(pend == 6'd0, "R3 one line drained", int'(pend), 0);
        thresh = 6'd2;
        send_desc(7);
        idle(5);
        check(pend == 6'd7, "R3 under two lines", int'(pend), 7);
        expect_burst(8);
        send_desc(1);
        idle(6);
        check(pend == 6'd0, "R3 two lines drained", int'(pend), 0);

        // R4: threshold zero, one descriptor per burst
        thresh = 6'd0; gran = 1'b1;
        expect_burst(1);
        send_desc(1);
        idle(6);
        expect_burst(1);
        send_desc(1);
        idle(6);
        check(pend == 6'd0, "R4 single bursts drained", int'(pend), 0);

        // R5: flush overrides threshold; empty flush dropped
        thresh = 6'd10;
        send_desc(5);
        idle(5);
        check(pend == 6'd5, "R5 held below threshold", int'(pend), 5);
        expect_burst(5);
        pulse_flush();
        idle(6);
        check(pend == 6'd0, "R5 flushed", int'(pend), 0);
        pulse_flush();
        idle(6);
        check(wb_req == 1'b0, "R5 empty flush ignored", int'(wb_req), 0);
        check(pend == 6'd0, "R5 empty flush pend", int'(pend), 0);

        // R7: completion in the acknowledge cycle is kept
        thresh = 6'd3; ack_delay = 1;
        expect_burst(4);
        send_desc(7);
        idle(3);
        check(pend == 6'd3, "R7 concurrent add at ack", int'(pend), 3);
        ack_delay = 0;
        expect_burst(3);
        pulse_flush();
        idle(6);
        check(pend == 6'd0, "R7 cleanup", int'(pend), 0);

        // R6 and R5: held request, flush during active request remembered
        ack_delay = 3;
        expect_burst(4);
        expect_burst(1);
        send_desc(4);
        @(negedge clk) begin desc_done = 1'b1; flush = 1'b1; end
        @(negedge clk) begin desc_done = 1'b0; flush = 1'b0; end
        check(wb_req == 1'b1, "R6 request held", int'(wb_req), 1);
        idle(12);
        check(pend == 6'd0, "R5 deferred flush served", int'(pend), 0);
        ack_delay = 0;

        // R8: saturation
        thresh = 6'd63; gran = 1'b1;
        expect_burst(63);
        send_desc(63);
        check(pend == 6'd63, "R8 saturated", int'(pend), 63);
        check(desc_ready == 1'b0, "R8 back-pressure", int'(desc_ready), 0);
        desc_done = 1'b1;
        @(negedge clk) desc_done = 1'b0;
        check(pend == 6'd63, "R8 completion dropped", int'(pend), 63);
        idle(4);
        check(pend == 6'd0, "R8 forced drain", int'(pend), 0);
        check(desc_ready == 1'b1, "R8 ready again", int'(desc_ready), 1);

        check(exp_q.size() == 0, "R6 all bursts seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule